// File: doc/BRIEF.md
# Digital frequency-locked loop controller

This block keeps a digitally tuned high-frequency oscillator at a chosen multiple of a 32.768 kHz reference. The reference clock is divided by sixteen to mark a measurement window 1/2048 s long. Each window boundary crosses into the high-frequency domain through a two-flop synchronizer. At every boundary the number of high-frequency cycles seen since the previous boundary is captured and compared with a 13-bit setpoint. The signed difference, scaled by a fixed power-of-two gain, moves an 18-bit control code that clamps at both ends. Over the 8 to 16 MHz tuning span of the oscillator, useful setpoints lie roughly between 3906 and 7812 counts.

With the loop switched off, the code stays where it is and can be overwritten from a load port. This lets firmware seed the oscillator near its target before closing the loop. An optional dither taken from an 8-bit maximal-length sequence can be added to the code the oscillator sees, which spreads its spectrum. A lock flag reports that the count has stayed within one cycle of the setpoint for several windows in a row. The block has no data stream: every pin is a plain level or strobe, with no valid/ready handshake, so there is no back-pressure to respect.

Top module: `fll_ctrl`

## Requirements
- R1: While `rst_n` is low, the stored code is 0x20000, `locked` is 0 and the dither sequence holds 0x01.
- R2: A window boundary occurs on every sixteenth rising edge of `ref_clk`. After two synchronizing flops, the measured value is the exact number of `hf_clk` cycles between two consecutive boundaries. The first boundary after reset only starts the count and updates nothing.
- R3: With `loop_en` high, each measured window changes the stored code by (target − measured) × 4, which is a left shift of 2.
- R4: The code update clamps at 0 and at 262143, and never wraps.
- R5: With `loop_en` low, measured windows leave the stored code unchanged.
- R6: With `loop_en` low, a one-cycle `load_stb` stores `load_val` on that clock edge. With `loop_en` high, `load_stb` is ignored.
- R7: The dither sequence shifts left once per measured window. The new bit 0 is the XOR of old bits 7, 5, 4 and 3 (x^8+x^6+x^5+x^4+1). The sequence never reaches zero.
- R8: With `spread_en` high, `dco_code` equals the stored code plus the 8-bit dither value, clamped at 262143. With `spread_en` low, `dco_code` equals the stored code.
- R9: `locked` rises after four consecutive measured windows in which `loop_en` is high and |target − measured| ≤ 1. The first measured window that fails either condition clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hf_clk | input | 1 | Oscillator clock that drives the counter and the loop |
| ref_clk | input | 1 | 32.768 kHz reference clock |
| rst_n | input | 1 | Asynchronous reset for both domains, active low |
| loop_en | input | 1 | Closes the loop when high |
| target | input | 13 | Setpoint, in oscillator cycles per window |
| load_val | input | 18 | Code value to store directly |
| load_stb | input | 1 | Writes `load_val` into the code while the loop is off |
| spread_en | input | 1 | Adds dither to the output code |
| dco_code | output | 18 | Control code applied to the oscillator |
| locked | output | 1 | Frequency-locked indication |

## Verification
A faulty window counter or synchronizer shows up at the first measured window. The code then moves by four times the counting error, so it differs from the predicted value in the very next check. A corrupted dither register shows up in `dco_code` within one window whenever spreading is on. The error then repeats on every later window, because the sequence only ever steps forward. A wrong lock streak either raises `locked` one window too early or too late, or keeps it high after an error of two counts. The bench drives the reference from the oscillator clock, so each window length is known exactly and every comparison is exact.

// File: rtl/fll_pkg.sv
package fll_pkg;
  localparam int CODE_WIDTH  = 18;
  localparam int TGT_WIDTH   = 13;
  localparam int COUNT_WIDTH = 14;
  localparam int DITH_WIDTH  = 8;
  localparam int REF_DIVIDE  = 16;
  localparam int SYNC_STAGES = 2;
  localparam int LOOP_SHIFT  = 2;
  localparam int LOCK_WINDOWS = 4;
endpackage

// File: rtl/fll_refdiv.sv
module fll_refdiv #(
  parameter int DIV = fll_pkg::REF_DIVIDE
) (
  input  logic ref_clk,
  input  logic rst_n,
  output logic win_tgl
);
  localparam int DW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_cnt;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      win_tgl <= 1'b0;
    end else if (div_cnt == LAST) begin
      div_cnt <= '0;
      win_tgl <= ~win_tgl;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/fll_meter.sv
module fll_meter #(
  parameter int CNT_W  = fll_pkg::COUNT_WIDTH,
  parameter int SYNC_N = fll_pkg::SYNC_STAGES
) (
  input  logic             hf_clk,
  input  logic             rst_n,
  input  logic             win_tgl,
  output logic [CNT_W-1:0] meas,
  output logic             meas_vld
);
  logic [SYNC_N:0]  sh;
  logic             bnd;
  logic             primed;
  logic [CNT_W-1:0] cnt;

  // synchronizer stages plus one history flop for edge detection
  always_ff @(posedge hf_clk or negedge rst_n) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[SYNC_N-1:0], win_tgl};
  end

  assign bnd = sh[SYNC_N] ^ sh[SYNC_N-1];

  always_ff @(posedge hf_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      meas     <= '0;
      meas_vld <= 1'b0;
      primed   <= 1'b0;
    end else if (bnd) begin
      cnt      <= CNT_W'(1);
      meas     <= primed ? cnt : meas;
      meas_vld <= primed;
      primed   <= 1'b1;
    end else begin
      meas_vld <= 1'b0;
      if (cnt != '1) cnt <= cnt + 1'b1;
    end
  end

  assert_vld_single_R2: assert property (@(posedge hf_clk) disable iff (!rst_n)
    meas_vld |=> !meas_vld);
endmodule

// File: rtl/fll_lfsr.sv
module fll_lfsr #(
  parameter int         W    = fll_pkg::DITH_WIDTH,
  parameter logic [W-1:0] TAPS = W'(8'hB8),
  parameter logic [W-1:0] SEED = W'(1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  output logic [W-1:0] state
);
  logic fb;
  assign fb = ^(state & TAPS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state <= SEED;
    else if (step) state <= {state[W-2:0], fb};
  end

  assert_lfsr_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0);
  assert_lfsr_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(state));
endmodule

// File: rtl/fll_loop.sv
module fll_loop #(
  parameter int CODE_W = fll_pkg::CODE_WIDTH,
  parameter int TGT_W  = fll_pkg::TGT_WIDTH,
  parameter int CNT_W  = fll_pkg::COUNT_WIDTH,
  parameter int DITH_W = fll_pkg::DITH_WIDTH,
  parameter int GAIN   = fll_pkg::LOOP_SHIFT,
  parameter int LOCK_N = fll_pkg::LOCK_WINDOWS,
  parameter logic [CODE_W-1:0] RESET_CODE = CODE_W'(1) << (CODE_W - 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic [TGT_W-1:0]  target,
  input  logic [CODE_W-1:0] load_val,
  input  logic              load_stb,
  input  logic              spread_en,
  input  logic [CNT_W-1:0]  meas,
  input  logic              meas_vld,
  input  logic [DITH_W-1:0] dither,
  output logic [CODE_W-1:0] dco_code,
  output logic              locked
);
  localparam int EW = ((CNT_W > TGT_W) ? CNT_W : TGT_W) + 2;
  localparam int SW = ((CODE_W > EW + GAIN) ? CODE_W : EW + GAIN) + 2;
  localparam int LW = $clog2(LOCK_N + 1);
  localparam logic signed [SW-1:0] CMAX = (SW'(1) <<< CODE_W) - SW'(1);
  localparam logic signed [EW-1:0] ONE  = EW'(1);

  logic signed [EW-1:0] err;
  logic signed [SW-1:0] sum;
  logic [CODE_W-1:0]    code_q, code_nxt;
  logic [CODE_W:0]      dsum;
  logic [LW-1:0]        streak;
  logic                 near;

  assign err  = $signed(EW'(target)) - $signed(EW'(meas));
  assign sum  = $signed(SW'(code_q)) + (SW'(err) <<< GAIN);
  assign near = (err <= ONE) && (err >= -ONE);

  always_comb begin
    if (sum[SW-1])       code_nxt = '0;
    else if (sum > CMAX) code_nxt = '1;
    else                 code_nxt = sum[CODE_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= RESET_CODE;
    end else if (loop_en) begin
      if (meas_vld) code_q <= code_nxt;
    end else if (load_stb) begin
      code_q <= load_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak <= '0;
      locked <= 1'b0;
    end else if (meas_vld) begin
      if (loop_en && near) begin
        if (streak < LW'(LOCK_N)) streak <= streak + 1'b1;
        locked <= (streak >= LW'(LOCK_N - 1));
      end else begin
        streak <= '0;
        locked <= 1'b0;
      end
    end
  end

  assign dsum     = {1'b0, code_q} + (CODE_W + 1)'(dither);
  assign dco_code = !spread_en ? code_q : (dsum[CODE_W] ? '1 : dsum[CODE_W-1:0]);

  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && !load_stb) |=> $stable(code_q));
  assert_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!loop_en && load_stb) |=> (code_q == $past(load_val)));
  assert_update_on_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_en && !meas_vld) |=> $stable(code_q));
  assert_lock_on_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_vld));
  assert_spread_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    spread_en |-> (dco_code >= code_q));
endmodule

// File: rtl/fll_ctrl.sv
module fll_ctrl #(
  parameter int CODE_W   = fll_pkg::CODE_WIDTH,
  parameter int TGT_W    = fll_pkg::TGT_WIDTH,
  parameter int CNT_W    = fll_pkg::COUNT_WIDTH,
  parameter int DITH_W   = fll_pkg::DITH_WIDTH,
  parameter int REF_DIV  = fll_pkg::REF_DIVIDE,
  parameter int SYNC_N   = fll_pkg::SYNC_STAGES,
  parameter int GAIN     = fll_pkg::LOOP_SHIFT,
  parameter int LOCK_N   = fll_pkg::LOCK_WINDOWS
) (
  input  logic              hf_clk,
  input  logic              ref_clk,
  input  logic              rst_n,
  input  logic              loop_en,
  input  logic [TGT_W-1:0]  target,
  input  logic [CODE_W-1:0] load_val,
  input  logic              load_stb,
  input  logic              spread_en,
  output logic [CODE_W-1:0] dco_code,
  output logic              locked
);
  logic              win_tgl;
  logic [CNT_W-1:0]  meas;
  logic              meas_vld;
  logic [DITH_W-1:0] dither;

  fll_refdiv #(.DIV(REF_DIV)) u_refdiv (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .win_tgl (win_tgl)
  );

  fll_meter #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) u_meter (
    .hf_clk   (hf_clk),
    .rst_n    (rst_n),
    .win_tgl  (win_tgl),
    .meas     (meas),
    .meas_vld (meas_vld)
  );

  fll_lfsr #(.W(DITH_W)) u_lfsr (
    .clk   (hf_clk),
    .rst_n (rst_n),
    .step  (meas_vld),
    .state (dither)
  );

  fll_loop #(
    .CODE_W(CODE_W), .TGT_W(TGT_W), .CNT_W(CNT_W), .DITH_W(DITH_W),
    .GAIN(GAIN), .LOCK_N(LOCK_N)
  ) u_loop (
    .clk       (hf_clk),
    .rst_n     (rst_n),
    .loop_en   (loop_en),
    .target    (target),
    .load_val  (load_val),
    .load_stb  (load_stb),
    .spread_en (spread_en),
    .meas      (meas),
    .meas_vld  (meas_vld),
    .dither    (dither),
    .dco_code  (dco_code),
    .locked    (locked)
  );
endmodule

// File: tb/fll_ctrl_test.sv
`timescale 1ns/1ps
module fll_ctrl_test;
  localparam int CMAX = 262143;

  logic        hf_clk = 1'b0;
  logic        ref_clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        loop_en = 1'b0;
  logic        load_stb = 1'b0;
  logic        spread_en = 1'b0;
  logic [12:0] target = '0;
  logic [17:0] load_val = '0;
  logic [17:0] dco_code;
  logic        locked;

  int checks = 0, fails = 0, bwin = 0, h_next = 6;
  int h_hist[0:1023];
  int m_code = 131072, m_streak = 0, m_lock = 0, m_lfsr = 1;

  always #10 hf_clk = ~hf_clk;

  fll_ctrl uut (
    .hf_clk(hf_clk), .ref_clk(ref_clk), .rst_n(rst_n), .loop_en(loop_en),
    .target(target), .load_val(load_val), .load_stb(load_stb),
    .spread_en(spread_en), .dco_code(dco_code), .locked(locked)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lfsr_step(int s);
    int fb;
    fb = ((s >> 7) ^ (s >> 5) ^ (s >> 4) ^ (s >> 3)) & 1;
    return ((s << 1) | fb) & 255;
  endfunction

  function automatic int exp_out();
    int v;
    v = spread_en ? m_code + m_lfsr : m_code;
    return (v > CMAX) ? CMAX : v;
  endfunction

  // reference generated from the oscillator clock: window length known exactly
  initial begin
    wait (rst_n);
    @(negedge hf_clk);
    forever begin : gen_loop
      int w;
      w = bwin + 1;
      h_hist[w % 1024] = h_next;
      for (int k = 0; k < 16; k++) begin
        ref_clk = 1'b1;
        repeat (h_hist[w % 1024]) @(negedge hf_clk);
        ref_clk = 1'b0;
        repeat (h_hist[w % 1024]) @(negedge hf_clk);
      end
      bwin = w;
    end
  end

  task automatic next_window(string req);
    int w0, w, meas, err;
    w0 = bwin;
    wait (bwin != w0);
    w = bwin;
    if (w >= 2) begin
      meas = 2 * h_hist[(w - 1) % 1024] + 30 * h_hist[w % 1024];
      err = int'(target) - meas;
      m_lfsr = lfsr_step(m_lfsr);
      if (loop_en) begin
        m_code = m_code + err * 4;
        if (m_code < 0) m_code = 0;
        if (m_code > CMAX) m_code = CMAX;
      end
      if (loop_en && err <= 1 && err >= -1) begin
        if (m_streak < 4) m_streak++;
      end else m_streak = 0;
      m_lock = (m_streak >= 4) ? 1 : 0;
    end
    repeat (8) @(negedge hf_clk);
    check({req, " code"}, int'(dco_code), exp_out());
    check({req, " lock R9"}, int'(locked), m_lock);
  endtask

  task automatic do_load(int v, string req);
    @(negedge hf_clk);
    load_val = 18'(v);
    load_stb = 1'b1;
    @(negedge hf_clk);
    load_stb = 1'b0;
    if (!loop_en) m_code = v;
    @(negedge hf_clk);
    check(req, int'(dco_code), exp_out());
  endtask

  initial begin
    repeat (200000) @(posedge hf_clk);
    fails++;
    $display("FAIL R2 watchdog actual=timeout expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge hf_clk);
    // R1: reset state; dither seed visible through the spread path
    check("R1 reset code", int'(dco_code), 131072);
    check("R1 reset lock", int'(locked), 0);
    spread_en = 1'b1;
    @(negedge hf_clk);
    check("R1 R8 reset dither", int'(dco_code), 131073);
    spread_en = 1'b0;
    @(negedge hf_clk);
    rst_n = 1'b1;

    // R2: first boundary only primes the counter
    loop_en = 1'b1;
    target = 13'd8000;
    next_window("R2 prime");

    // R3/R2: sweep of window lengths and setpoints
    for (int h = 4; h <= 8; h++) begin
      h_next = h;
      for (int d = -30; d <= 30; d += 15) begin
        target = 13'(32 * h + d);
        next_window("R3 sweep");
      end
    end

    // R9: lock streak, boundary errors of 0, +1, -1 and +2
    h_next = 6;
    target = 13'd192;
    for (int i = 0; i < 7; i++) next_window("R9 streak");
    target = 13'd193;
    next_window("R9 plus one");
    target = 13'd191;
    next_window("R9 minus one");
    target = 13'd194;
    next_window("R9 plus two");
    target = 13'd192;
    for (int i = 0; i < 5; i++) next_window("R9 relock");

    // R5: loop off holds the code, clears lock
    loop_en = 1'b0;
    target = 13'd8191;
    for (int i = 0; i < 3; i++) next_window("R5 hold");

    // R6: direct load, then a load ignored with the loop on
    do_load(12345, "R6 load");
    loop_en = 1'b1;
    do_load(777, "R6 ignored");
    loop_en = 1'b0;

    // R4: clamp at the top and at zero
    do_load(262000, "R6 load high");
    loop_en = 1'b1;
    target = 13'd8191;
    next_window("R4 clamp high");
    next_window("R4 stay high");
    loop_en = 1'b0;
    do_load(5, "R6 load low");
    loop_en = 1'b1;
    target = 13'd0;
    next_window("R4 clamp low");
    next_window("R4 stay low");

    // R7/R8: dither sequence seen through the output
    loop_en = 1'b0;
    spread_en = 1'b1;
    do_load(100000, "R8 load");
    for (int i = 0; i < 6; i++) begin
      next_window("R8 spread");
      check("R7 sequence", int'(dco_code) - 100000, m_lfsr);
    end
    do_load(262143, "R8 clamp");
    next_window("R8 clamp window");
    do_load(131072, "R8 reload");
    loop_en = 1'b1;
    target = 13'd190;
    for (int i = 0; i < 4; i++) next_window("R8 spread loop");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule